// File: doc/BRIEF.md
# Masked unsigned widening sum reducer

This block folds a vector of unsigned elements into one sum that is twice as wide as an element. A command carries the active element count, a start index, a mask-enable flag, an element-width code and a wide seed. The block then takes element data four lanes per group over a valid/ready stream. The accumulator begins at the seed. Each element that takes part is zero-extended to the doubled width before it is added.

An element takes part only if its index lies below the active count and, when masking is enabled, its mask bit is one. After the last group is taken, the block sends out the single scalar result with a write strobe and a done pulse. The result goes to element zero of the destination. Decode, register file access, writeback policy for the other destination elements, and traps are all handled outside this block.

Top module: `wred_sum_top`

## Requirements
- R1: A command accepted with a nonzero start index, or with width code 3, gives `done` and `err` high in the next cycle. `res_we` stays low, `result` keeps its value, and nothing is accumulated.
- R2: A legal command accepted with an active count of zero gives `done` high in the next cycle, with `err` and `res_we` low and `result` unchanged.
- R3: The width code selects the element width: 0 is 8 bits, 1 is 16 bits and 2 is 32 bits. Element i of a group sits in the low bits of `dat_elems[32*i +: 32]`. It is read as unsigned and zero-extended to twice the element width.
- R4: The accumulator starts from the low 2×width bits of `cmd_seed`.
- R5: With `cmd_mask_en` set, lane i of a group contributes nothing when `dat_mask[i]` is 0.
- R6: With `cmd_mask_en` clear, every element below the active count takes part, whatever the value of `dat_mask`.
- R7: Element number 4·g+i (group g, lane i) is left out when it is not below the active count.
- R8: The sum wraps modulo 2^(2×width). Bits of `result` at and above 2×width are zero.
- R9: `cmd_ready` is high only while idle and `dat_ready` is high only while a reduction runs. The two are never high together. A group is taken on a cycle with `dat_valid` and `dat_ready` both high.
- R10: One cycle after the final group is taken, `done` and `res_we` are high for one cycle, `err` is low, and `result` holds the sum.
- R11: `result` changes only in a cycle where `res_we` is high. It reads zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command taken |
| cmd_len | input | 8 | Active element count |
| cmd_start_idx | input | 8 | Start index, must be zero |
| cmd_mask_en | input | 1 | Enable per-element masking |
| cmd_sew | input | 2 | Element width code |
| cmd_seed | input | 64 | Wide seed value |
| dat_valid | input | 1 | Element group present |
| dat_ready | output | 1 | Group taken |
| dat_elems | input | 128 | Four element slots of 32 bits |
| dat_mask | input | 4 | Mask bit per lane |
| done | output | 1 | Completion pulse |
| err | output | 1 | Illegal command flag |
| res_we | output | 1 | Result written this cycle |
| result | output | 64 | Scalar sum for destination element zero |

## Verification
Masking and the active-count cut-off can both act on lanes of the same final group. The active count can end partway through a group, while mask bits clear other lanes of that same group. Counts that are not multiples of four are driven together with random and fixed mask patterns, including all-zero and all-one masks. Each completed sum is compared with a bench model that visits elements one at a time. A lane dropped for the wrong reason, or dropped twice, shows up as a wrong sum. The testbench also starts a new command in the cycle a done pulse appears, and checks that the earlier result is kept.

// File: rtl/wred_pkg.sv
package wred_pkg;
    localparam int MAX_ELEM_W = 32;

    typedef enum logic [1:0] {
        SEW_8   = 2'd0,
        SEW_16  = 2'd1,
        SEW_32  = 2'd2,
        SEW_BAD = 2'd3
    } sew_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } wred_state_e;
endpackage

// File: rtl/wred_lane.sv
module wred_lane
    import wred_pkg::*;
#(
    parameter int ELEM_W = MAX_ELEM_W,
    parameter int ACC_W  = 2 * ELEM_W
) (
    input  logic [ELEM_W-1:0] slot,
    input  sew_e              sew,
    input  logic              enable,
    output logic [ACC_W-1:0]  contrib
);
    logic [ELEM_W-1:0] emask;
    logic [ELEM_W-1:0] picked;

    // Keep only the bits of the selected element width.
    always_comb begin
        emask = '0;
        for (int b = 0; b < ELEM_W; b++) begin
            if (b < (8 << sew)) emask[b] = 1'b1;
        end
        picked = slot & emask;
    end

    assign contrib = enable ? {{(ACC_W-ELEM_W){1'b0}}, picked} : '0;
endmodule

// File: rtl/wred_group_sum.sv
module wred_group_sum
    import wred_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ELEM_W = MAX_ELEM_W,
    parameter int ACC_W  = 2 * ELEM_W,
    parameter int LEN_W  = 8
) (
    input  logic [LANES*ELEM_W-1:0] elems,
    input  logic [LANES-1:0]        mask,
    input  logic                    mask_en,
    input  sew_e                    sew,
    input  logic [LEN_W-1:0]        base_idx,
    input  logic [LEN_W-1:0]        len,
    output logic [ACC_W-1:0]        group_sum
);
    logic [ACC_W-1:0] contrib [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LEN_W:0] idx;
        logic           in_len;
        logic           live;
        assign idx    = {1'b0, base_idx} + (LEN_W+1)'(i);
        assign in_len = idx < {1'b0, len};
        assign live   = in_len && (!mask_en || mask[i]);

        wred_lane #(.ELEM_W(ELEM_W), .ACC_W(ACC_W)) u_lane (
            .slot    (elems[i*ELEM_W +: ELEM_W]),
            .sew     (sew),
            .enable  (live),
            .contrib (contrib[i])
        );
    end

    // Modular addition: order of the lane additions cannot change the low bits.
    always_comb begin
        group_sum = '0;
        for (int i = 0; i < LANES; i++) begin
            group_sum = group_sum + contrib[i];
        end
    end
endmodule

// File: rtl/wred_sum_top.sv
module wred_sum_top
    import wred_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ELEM_W = MAX_ELEM_W,
    parameter int LEN_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    output logic                    cmd_ready,
    input  logic [LEN_W-1:0]        cmd_len,
    input  logic [LEN_W-1:0]        cmd_start_idx,
    input  logic                    cmd_mask_en,
    input  logic [1:0]              cmd_sew,
    input  logic [2*ELEM_W-1:0]     cmd_seed,
    input  logic                    dat_valid,
    output logic                    dat_ready,
    input  logic [LANES*ELEM_W-1:0] dat_elems,
    input  logic [LANES-1:0]        dat_mask,
    output logic                    done,
    output logic                    err,
    output logic                    res_we,
    output logic [2*ELEM_W-1:0]     result
);
    localparam int ACC_W = 2 * ELEM_W;

    typedef struct packed {
        wred_state_e      state;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] base;
        logic             mask_en;
        sew_e             sew;
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] result;
        logic             done;
        logic             err;
        logic             we;
    } wred_regs_t;

    wred_regs_t r_q, r_d;

    function automatic logic [ACC_W-1:0] acc_mask(sew_e s);
        logic [ACC_W-1:0] m;
        m = '0;
        for (int b = 0; b < ACC_W; b++) begin
            if (b < (16 << s)) m[b] = 1'b1;
        end
        return m;
    endfunction

    sew_e             cmd_sew_e;
    logic [ACC_W-1:0] grp_sum;
    logic [LEN_W:0]   grp_end;
    logic             last_grp;
    logic [ACC_W-1:0] acc_next;

    assign cmd_sew_e = sew_e'(cmd_sew);
    assign cmd_ready = (r_q.state == ST_IDLE);
    assign dat_ready = (r_q.state == ST_BUSY);
    assign grp_end   = {1'b0, r_q.base} + (LEN_W+1)'(LANES);
    assign last_grp  = grp_end >= {1'b0, r_q.len};

    wred_group_sum #(
        .LANES(LANES), .ELEM_W(ELEM_W), .ACC_W(ACC_W), .LEN_W(LEN_W)
    ) u_group (
        .elems     (dat_elems),
        .mask      (dat_mask),
        .mask_en   (r_q.mask_en),
        .sew       (r_q.sew),
        .base_idx  (r_q.base),
        .len       (r_q.len),
        .group_sum (grp_sum)
    );

    assign acc_next = (r_q.acc + grp_sum) & acc_mask(r_q.sew);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        r_d.we   = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (cmd_start_idx != '0 || cmd_sew_e == SEW_BAD) begin
                        r_d.done = 1'b1;
                        r_d.err  = 1'b1;
                    end else if (cmd_len == '0) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.state   = ST_BUSY;
                        r_d.len     = cmd_len;
                        r_d.base    = '0;
                        r_d.mask_en = cmd_mask_en;
                        r_d.sew     = cmd_sew_e;
                        r_d.acc     = cmd_seed & acc_mask(cmd_sew_e);
                    end
                end
            end
            ST_BUSY: begin
                if (dat_valid) begin
                    if (last_grp) begin
                        r_d.state  = ST_IDLE;
                        r_d.result = acc_next;
                        r_d.done   = 1'b1;
                        r_d.we     = 1'b1;
                    end else begin
                        r_d.acc  = acc_next;
                        r_d.base = grp_end[LEN_W-1:0];
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, sew: SEW_8, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign done   = r_q.done;
    assign err    = r_q.err;
    assign res_we = r_q.we;
    assign result = r_q.result;

    // R10: completion follows the final group by one cycle
    a_r10_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_valid && dat_ready && last_grp) |=> (done && res_we && !err));

    // R1: an illegal command never writes
    a_r1_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && !res_we));

    // R2: zero-length command completes without a write
    a_r2_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_start_idx == '0 && cmd_sew != 2'd3 && cmd_len == '0)
        |=> (done && !res_we && !err));

    // R11: result moves only with the write strobe
    a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !res_we |-> $stable(result));

    // R8: bits above the doubled width stay clear
    a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> ((result & ~acc_mask(r_q.sew)) == '0));

    // R9: command and data sides are never ready together
    a_r9_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ready && dat_ready));
endmodule

// File: tb/wred_sum_top_bench.sv
module wred_sum_top_bench;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         cmd_valid;
    logic         cmd_ready;
    logic [7:0]   cmd_len;
    logic [7:0]   cmd_start_idx;
    logic         cmd_mask_en;
    logic [1:0]   cmd_sew;
    logic [63:0]  cmd_seed;
    logic         dat_valid;
    logic         dat_ready;
    logic [127:0] dat_elems;
    logic [3:0]   dat_mask;
    logic         done;
    logic         err;
    logic         res_we;
    logic [63:0]  result;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [63:0] last_result = '0;

    always #10 clk = ~clk;

    wred_sum_top u_wred_sum_top (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_len(cmd_len),
        .cmd_start_idx(cmd_start_idx), .cmd_mask_en(cmd_mask_en),
        .cmd_sew(cmd_sew), .cmd_seed(cmd_seed),
        .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_elems(dat_elems),
        .dat_mask(dat_mask), .done(done), .err(err), .res_we(res_we),
        .result(result)
    );

    function automatic logic [63:0] wmask(int bits);
        logic [63:0] m;
        m = '0;
        for (int b = 0; b < 64; b++) if (b < bits) m[b] = 1'b1;
        return m;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // pat: 0 random data, 1 all ones. mfix: use mpat as mask for every group.
    task automatic run_op(input int sew, input int len, input bit men,
                          input logic [63:0] seed, input int sidx, input int pat,
                          input bit mfix, input logic [3:0] mpat, input string req);
        logic [63:0] exp;
        int          ngrp;
        int          w;
        w = 8 << sew;
        chk(cmd_ready === 1'b1, "R9 cmd_ready idle", 64'(cmd_ready), 64'd1);
        cmd_valid     = 1'b1;
        cmd_len       = 8'(len);
        cmd_start_idx = 8'(sidx);
        cmd_mask_en   = men;
        cmd_sew       = 2'(sew);
        cmd_seed      = seed;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (sidx != 0 || sew == 3) begin
            chk(done && err && !res_we, "R1 err flags", {61'd0, done, err, res_we}, 64'b110);
            chk(result === last_result, "R1 result held", result, last_result);
            return;
        end
        if (len == 0) begin
            chk(done && !err && !res_we, "R2 zero len flags", {61'd0, done, err, res_we}, 64'b100);
            chk(result === last_result, "R2 result held", result, last_result);
            return;
        end
        exp  = seed & wmask(2 * w);
        ngrp = (len + 3) / 4;
        for (int g = 0; g < ngrp; g++) begin
            if ($urandom % 4 == 0) begin
                dat_valid = 1'b0;
                dat_elems = {$urandom, $urandom, $urandom, $urandom};
                @(posedge clk);
                @(negedge clk);
                chk(!cmd_ready && dat_ready && !done, "R9 busy during bubble",
                    {62'd0, cmd_ready, dat_ready}, 64'b01);
            end
            dat_valid = 1'b1;
            dat_mask  = mfix ? mpat : 4'($urandom);
            for (int i = 0; i < 4; i++) begin
                dat_elems[i*32 +: 32] = (pat == 1) ? 32'hFFFF_FFFF : $urandom;
                if (g * 4 + i < len && (!men || dat_mask[i]))
                    exp = (exp + (64'(dat_elems[i*32 +: 32]) & wmask(w))) & wmask(2 * w);
            end
            @(posedge clk);
            @(negedge clk);
            dat_valid = 1'b0;
            if (g != ngrp - 1)
                chk(!done && !res_we, "R10 no early done", {62'd0, done, res_we}, 64'd0);
        end
        chk(done && res_we && !err, "R10 done strobe", {61'd0, done, res_we, err}, 64'b110);
        chk(result === exp, req, result, exp);
        last_result = exp;
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd4242);
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_len = '0; cmd_start_idx = '0;
        cmd_mask_en = 1'b0; cmd_sew = '0; cmd_seed = '0;
        dat_valid = 1'b0; dat_elems = '0; dat_mask = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(cmd_ready && !dat_ready && !done && !err && !res_we,
            "R9 reset ready state", {59'd0, cmd_ready, dat_ready, done, err, res_we}, 64'b10000);
        chk(result === 64'd0, "R11 reset result", result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op(0, 4,  1'b0, 64'h0000_0000_0000_FFF0, 0, 1, 1'b0, 4'h0, "R8 wrap 16 bit");
        run_op(2, 5,  1'b1, 64'h1,                    0, 0, 1'b1, 4'b1010, "R5 R7 mask and cut");
        run_op(1, 7,  1'b0, 64'hDEAD_BEEF_1234_5678,  0, 0, 1'b1, 4'b0000, "R6 R4 mask ignored");
        run_op(1, 6,  1'b1, 64'hFFFF_FFFF_FFFF_FFFF,  0, 1, 1'b1, 4'b0000, "R5 all masked seed only");
        run_op(2, 9,  1'b0, 64'hFFFF_FFFF_FFFF_FFFF,  0, 1, 1'b0, 4'h0, "R8 wrap 64 bit");
        run_op(0, 3,  1'b0, 64'h0,                    0, 0, 1'b0, 4'h0, "R3 8 bit extend");
        run_op(1, 0,  1'b0, 64'h5,                    0, 0, 1'b0, 4'h0, "R2");
        run_op(2, 8,  1'b0, 64'h7,                    2, 0, 1'b0, 4'h0, "R1");
        run_op(3, 8,  1'b0, 64'h7,                    0, 0, 1'b0, 4'h0, "R1");
        run_op(2, 1,  1'b1, 64'h0,                    0, 1, 1'b1, 4'b0001, "R7 single lane");

        for (int k = 0; k < 60; k++) begin
            run_op(int'($urandom % 3), int'($urandom % 41), 1'($urandom),
                   {$urandom, $urandom}, 0, int'($urandom % 4 == 0), 1'b0, 4'h0,
                   "R3 R4 R5 R7 random sum");
        end
        run_op(0, 0, 1'b0, 64'h0, 0, 0, 1'b0, 4'h0, "R2");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule